// File: doc/BRIEF.md
# Pointer-Addressed Buffer RAM Port

This block gives a host processor access to a 2048 x 8 buffer RAM through a four-entry register window. The window does not expose RAM addresses directly. Instead, the host loads an 11-bit address pointer, then moves bytes through a single data register. A mode field decides two things: whether the data register serves reads (prefetch) or writes (commit), and whether the pointer steps forward after each data access.

Reads never wait on the RAM. Loading the low pointer byte starts a fetch of the addressed location into the data register, and the host collects the byte later. Writes land in the data register at once and reach the RAM over the following cycle. Every internal RAM operation finishes within two clock cycles. That is shorter than the minimum host access spacing of three cycles, so the host never needs a ready signal.

Register select codes on `host_addr` are: 0 = pointer low byte, 1 = pointer high/mode, 2 = data, 3 = unused.

Top module: `ptr_ram_port`

## Requirements
- R1: After reset, the pointer is 0, auto-increment and read direction are clear, and the data register is 0. Reads of select codes 0, 1 and 2 therefore return 0x00.
- R2: A write to select 0 sets the pointer to {staged high bits, written byte}. Select 0 reads back pointer bits 7..0. Select 1 reads back {auto-increment (bit 7), read direction (bit 6), 000, pointer bits 10..8}.
- R3: A write to select 1 only stages its fields: bits 2..0 are the pointer high bits, bit 6 is the read direction and bit 7 is auto-increment. None of them takes effect, or shows on a select 1 read, until the next select 0 write.
- R4: A select 0 write with the staged read direction set fetches the RAM byte at the new pointer into the data register. Two clock cycles after the access, that byte is readable.
- R5: With read direction set and auto-increment clear, a data read fetches nothing from RAM. It returns the same byte again and leaves the pointer unchanged.
- R6: With read direction and auto-increment both set, each data read returns the current byte, advances the pointer by one and fetches the next location.
- R7: A data write places the byte in the data register in the access cycle's edge. The byte is written into the RAM at the pointer on the next cycle, and reading the data register returns it.
- R8: With read direction clear, a data write advances the pointer by one after the commit when auto-increment is set, and leaves it unchanged when auto-increment is clear.
- R9: The pointer wraps from 2047 to 0 when it advances.
- R10: Read data for any select is presented combinationally in the access cycle, with no wait state. Each internal prefetch or commit ends within two cycles of the access that started it.
- R11: Writes to select 3 change no state. Reads of select 3 return 0x00.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| host_sel | input | 1 | Host access strobe, one cycle per access |
| host_wr | input | 1 | 1 = write access, 0 = read access |
| host_addr | input | 2 | Register select (0 ptr low, 1 ptr high/mode, 2 data, 3 unused) |
| host_wdata | input | 8 | Write data |
| host_rdata | output | 8 | Read data for the selected register, valid in the access cycle |

## Verification
The assertions assume that a host access never arrives while a prefetch or commit is still running. In other words, accesses are at least three cycles apart, and one of the checks guards this assumption directly. The bench access task holds each strobe for one cycle and then idles for two cycles before the next access. The bench reads the prefetched byte exactly when it first becomes valid. Both wrap-around and auto-increment are exercised in write mode and in read mode over the same RAM locations, so the bench only reads locations it has written earlier.

// File: rtl/ptr_ram_pkg.sv
package ptr_ram_pkg;
  typedef enum logic [1:0] {
    REG_PLO  = 2'd0,
    REG_PHI  = 2'd1,
    REG_DATA = 2'd2,
    REG_NONE = 2'd3
  } reg_sel_e;

  typedef enum logic [1:0] {
    OP_IDLE   = 2'd0,
    OP_FETCH  = 2'd1,
    OP_LOAD   = 2'd2,
    OP_COMMIT = 2'd3
  } op_state_e;
endpackage

// File: rtl/ptr_ram_sram.sv
module ptr_ram_sram #(
  parameter int DEPTH  = 2048,
  parameter int DATA_W = 8,
  localparam int AW    = $clog2(DEPTH)
) (
  input  logic              clk,
  input  logic              en,
  input  logic              we,
  input  logic [AW-1:0]     addr,
  input  logic [DATA_W-1:0] d,
  output logic [DATA_W-1:0] q
);
  logic [DATA_W-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (en) begin
      if (we) mem[addr] <= d;
      q <= mem[addr];
    end
  end
endmodule

// File: rtl/ptr_ram_regs.sv
module ptr_ram_regs #(
  parameter int PTR_W = 11,
  parameter int HI_W  = 3,
  localparam int LO_W = PTR_W - HI_W
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             hi_wr,
  input  logic [HI_W-1:0]  hi_bits,
  input  logic             hi_ainc,
  input  logic             hi_rd,
  input  logic             lo_wr,
  input  logic [LO_W-1:0]  lo_bits,
  input  logic             adv,
  output logic [PTR_W-1:0] ptr_q,
  output logic             ainc_q,
  output logic             rd_q,
  output logic             stg_rd_q
);
  logic [HI_W-1:0]  stg_hi_q, stg_hi_d;
  logic             stg_ainc_q, stg_ainc_d, stg_rd_d;
  logic [PTR_W-1:0] ptr_d;
  logic             ainc_d, rd_d;

  always_comb begin
    stg_hi_d   = stg_hi_q;
    stg_ainc_d = stg_ainc_q;
    stg_rd_d   = stg_rd_q;
    ptr_d      = ptr_q;
    ainc_d     = ainc_q;
    rd_d       = rd_q;
    if (hi_wr) begin
      stg_hi_d   = hi_bits;
      stg_ainc_d = hi_ainc;
      stg_rd_d   = hi_rd;
    end
    if (lo_wr) begin
      ptr_d  = {stg_hi_q, lo_bits};
      ainc_d = stg_ainc_q;
      rd_d   = stg_rd_q;
    end else if (adv) begin
      ptr_d = ptr_q + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stg_hi_q   <= '0;
      stg_ainc_q <= 1'b0;
      stg_rd_q   <= 1'b0;
      ptr_q      <= '0;
      ainc_q     <= 1'b0;
      rd_q       <= 1'b0;
    end else begin
      stg_hi_q   <= stg_hi_d;
      stg_ainc_q <= stg_ainc_d;
      stg_rd_q   <= stg_rd_d;
      ptr_q      <= ptr_d;
      ainc_q     <= ainc_d;
      rd_q       <= rd_d;
    end
  end

  // R3
  hi_staged_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (hi_wr && !lo_wr && !adv) |=> ($stable(ptr_q) && $stable(ainc_q) && $stable(rd_q)));

  // R9
  ptr_wrap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (adv && !lo_wr && (&ptr_q)) |=> (ptr_q == '0));
endmodule

// File: rtl/ptr_ram_seq.sv
module ptr_ram_seq
  import ptr_ram_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              host_sel,
  input  logic              host_wr,
  input  reg_sel_e          host_reg,
  input  logic [DATA_W-1:0] host_wdata,
  input  logic              ainc,
  input  logic              rd_dir,
  input  logic              stg_rd,
  input  logic [DATA_W-1:0] ram_q,
  output logic              lo_wr,
  output logic              hi_wr,
  output logic              adv,
  output logic              ram_en,
  output logic              ram_we,
  output logic [DATA_W-1:0] data_q
);
  op_state_e         st_q, st_d;
  logic [DATA_W-1:0] data_d;
  logic              dat_wr, dat_rd, rd_step;

  always_comb begin
    lo_wr   = host_sel && host_wr && (host_reg == REG_PLO);
    hi_wr   = host_sel && host_wr && (host_reg == REG_PHI);
    dat_wr  = host_sel && host_wr && (host_reg == REG_DATA);
    dat_rd  = host_sel && !host_wr && (host_reg == REG_DATA);
    rd_step = dat_rd && rd_dir && ainc;
    adv     = rd_step || ((st_q == OP_COMMIT) && ainc && !rd_dir);
    ram_en  = (st_q == OP_FETCH) || (st_q == OP_COMMIT);
    ram_we  = (st_q == OP_COMMIT);
  end

  always_comb begin
    st_d   = st_q;
    data_d = data_q;
    case (st_q)
      OP_IDLE: begin
        if ((lo_wr && stg_rd) || rd_step) st_d = OP_FETCH;
        else if (dat_wr)                  st_d = OP_COMMIT;
      end
      OP_FETCH: st_d = OP_LOAD;
      OP_LOAD:  st_d = OP_IDLE;
      default:  st_d = OP_IDLE;
    endcase
    if (dat_wr)                data_d = host_wdata;
    else if (st_q == OP_LOAD)  data_d = ram_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q   <= OP_IDLE;
      data_q <= '0;
    end else begin
      st_q   <= st_d;
      data_q <= data_d;
    end
  end

  // R10
  host_gap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    host_sel |-> (st_q == OP_IDLE));

  // R10
  op_len_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ((st_q == OP_LOAD) || (st_q == OP_COMMIT)) |=> (st_q == OP_IDLE));

  // R4
  fetch_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (lo_wr && stg_rd && (st_q == OP_IDLE)) |=> (st_q == OP_FETCH));

  // R5
  hold_data_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (dat_rd && !ainc && (st_q == OP_IDLE)) |=> ($stable(data_q) && (st_q == OP_IDLE)));

  // R7
  commit_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (dat_wr && (st_q == OP_IDLE)) |=> ((st_q == OP_COMMIT) && (data_q == $past(host_wdata))));
endmodule

// File: rtl/ptr_ram_port.sv
module ptr_ram_port
  import ptr_ram_pkg::*;
#(
  parameter int DEPTH  = 2048,
  parameter int DATA_W = 8,
  localparam int PTR_W = $clog2(DEPTH),
  localparam int HI_W  = PTR_W - DATA_W,
  localparam int PAD_W = DATA_W - 2 - HI_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              host_sel,
  input  logic              host_wr,
  input  logic [1:0]        host_addr,
  input  logic [DATA_W-1:0] host_wdata,
  output logic [DATA_W-1:0] host_rdata
);
  logic [1:0]        rst_pipe;
  logic              rst_sync_n;
  reg_sel_e          host_reg;
  logic              lo_wr, hi_wr, adv, ram_en, ram_we;
  logic              ainc, rd_dir, stg_rd;
  logic [PTR_W-1:0]  ptr;
  logic [DATA_W-1:0] ram_q, data_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_pipe <= 2'b00;
    else        rst_pipe <= {rst_pipe[0], 1'b1};
  end
  assign rst_sync_n = rst_pipe[1];
  assign host_reg   = reg_sel_e'(host_addr);

  ptr_ram_regs #(.PTR_W(PTR_W), .HI_W(HI_W)) u_regs (
    .clk      (clk),
    .rst_n    (rst_sync_n),
    .hi_wr    (hi_wr),
    .hi_bits  (host_wdata[HI_W-1:0]),
    .hi_ainc  (host_wdata[DATA_W-1]),
    .hi_rd    (host_wdata[DATA_W-2]),
    .lo_wr    (lo_wr),
    .lo_bits  (host_wdata),
    .adv      (adv),
    .ptr_q    (ptr),
    .ainc_q   (ainc),
    .rd_q     (rd_dir),
    .stg_rd_q (stg_rd)
  );

  ptr_ram_seq #(.DATA_W(DATA_W)) u_seq (
    .clk        (clk),
    .rst_n      (rst_sync_n),
    .host_sel   (host_sel),
    .host_wr    (host_wr),
    .host_reg   (host_reg),
    .host_wdata (host_wdata),
    .ainc       (ainc),
    .rd_dir     (rd_dir),
    .stg_rd     (stg_rd),
    .ram_q      (ram_q),
    .lo_wr      (lo_wr),
    .hi_wr      (hi_wr),
    .adv        (adv),
    .ram_en     (ram_en),
    .ram_we     (ram_we),
    .data_q     (data_q)
  );

  ptr_ram_sram #(.DEPTH(DEPTH), .DATA_W(DATA_W)) u_ram (
    .clk  (clk),
    .en   (ram_en),
    .we   (ram_we),
    .addr (ptr),
    .d    (data_q),
    .q    (ram_q)
  );

  always_comb begin
    case (host_reg)
      REG_PLO:  host_rdata = ptr[DATA_W-1:0];
      REG_PHI:  host_rdata = {ainc, rd_dir, {PAD_W{1'b0}}, ptr[PTR_W-1:DATA_W]};
      REG_DATA: host_rdata = data_q;
      default:  host_rdata = '0;
    endcase
  end

  // R11
  idle_sel_chk: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (host_sel && (host_reg == REG_NONE)) |=> ($stable(ptr) && $stable(data_q)));
endmodule

// File: tb/sim_ptr_ram_port.sv
`timescale 1ns/1ps
module sim_ptr_ram_port;
  logic       clk = 1'b0;
  logic       rst_n;
  logic       host_sel, host_wr;
  logic [1:0] host_addr;
  logic [7:0] host_wdata, host_rdata;

  int checks = 0;
  int errors = 0;
  bit done   = 1'b0;

  always #4 clk = ~clk;

  ptr_ram_port u0 (
    .clk        (clk),
    .rst_n      (rst_n),
    .host_sel   (host_sel),
    .host_wr    (host_wr),
    .host_addr  (host_addr),
    .host_wdata (host_wdata),
    .host_rdata (host_rdata)
  );

  typedef struct packed {
    logic       wr;
    logic [1:0] sel;
    logic [7:0] wd;
    logic       chk;
    logic [7:0] exp;
    logic [7:0] req;
  } vec_t;

  localparam int NV = 39;
  localparam vec_t VEC [NV] = '{
    '{1'b1, 2'd1, 8'h05, 1'b0, 8'h00, 8'd3},   // R3 stage hi=5
    '{1'b0, 2'd1, 8'h00, 1'b1, 8'h00, 8'd3},   // R3 not yet visible
    '{1'b1, 2'd0, 8'h10, 1'b0, 8'h00, 8'd2},   // R2 ptr=0x510
    '{1'b0, 2'd1, 8'h00, 1'b1, 8'h05, 8'd2},   // R2
    '{1'b0, 2'd0, 8'h00, 1'b1, 8'h10, 8'd2},   // R2
    '{1'b1, 2'd2, 8'hA5, 1'b0, 8'h00, 8'd7},   // R7 commit @510
    '{1'b0, 2'd2, 8'h00, 1'b1, 8'hA5, 8'd7},   // R7
    '{1'b0, 2'd0, 8'h00, 1'b1, 8'h10, 8'd8},   // R8 no advance
    '{1'b1, 2'd1, 8'h87, 1'b0, 8'h00, 8'd8},   // R8 ainc, write dir
    '{1'b1, 2'd0, 8'hFE, 1'b0, 8'h00, 8'd8},   // ptr=0x7FE
    '{1'b0, 2'd1, 8'h00, 1'b1, 8'h87, 8'd2},   // R2
    '{1'b1, 2'd2, 8'h11, 1'b0, 8'h00, 8'd8},   // @7FE
    '{1'b0, 2'd0, 8'h00, 1'b1, 8'hFF, 8'd8},   // R8 advanced
    '{1'b1, 2'd2, 8'h22, 1'b0, 8'h00, 8'd9},   // @7FF
    '{1'b0, 2'd0, 8'h00, 1'b1, 8'h00, 8'd9},   // R9 wrap
    '{1'b0, 2'd1, 8'h00, 1'b1, 8'h80, 8'd9},   // R9
    '{1'b1, 2'd2, 8'h33, 1'b0, 8'h00, 8'd8},   // @000
    '{1'b1, 2'd2, 8'h44, 1'b0, 8'h00, 8'd8},   // @001
    '{1'b1, 2'd2, 8'h55, 1'b0, 8'h00, 8'd8},   // @002
    '{1'b0, 2'd2, 8'h00, 1'b1, 8'h55, 8'd7},   // R7
    '{1'b0, 2'd0, 8'h00, 1'b1, 8'h03, 8'd8},   // R8
    '{1'b1, 2'd1, 8'h45, 1'b0, 8'h00, 8'd4},   // R4 read dir, hi=5
    '{1'b1, 2'd0, 8'h10, 1'b0, 8'h00, 8'd4},   // prefetch @510
    '{1'b0, 2'd2, 8'h00, 1'b1, 8'hA5, 8'd4},   // R4
    '{1'b0, 2'd2, 8'h00, 1'b1, 8'hA5, 8'd5},   // R5 same byte
    '{1'b0, 2'd0, 8'h00, 1'b1, 8'h10, 8'd5},   // R5 ptr held
    '{1'b0, 2'd1, 8'h00, 1'b1, 8'h45, 8'd2},   // R2
    '{1'b1, 2'd1, 8'hC7, 1'b0, 8'h00, 8'd6},   // R6 read dir + ainc
    '{1'b1, 2'd0, 8'hFE, 1'b0, 8'h00, 8'd6},   // prefetch @7FE
    '{1'b0, 2'd2, 8'h00, 1'b1, 8'h11, 8'd6},   // R6
    '{1'b0, 2'd0, 8'h00, 1'b1, 8'hFF, 8'd6},   // R6
    '{1'b0, 2'd2, 8'h00, 1'b1, 8'h22, 8'd6},   // R6
    '{1'b0, 2'd0, 8'h00, 1'b1, 8'h00, 8'd9},   // R9 read wrap
    '{1'b0, 2'd2, 8'h00, 1'b1, 8'h33, 8'd9},   // R9
    '{1'b0, 2'd2, 8'h00, 1'b1, 8'h44, 8'd6},   // R6
    '{1'b1, 2'd3, 8'hFF, 1'b0, 8'h00, 8'd11},  // R11 unused select
    '{1'b0, 2'd3, 8'h00, 1'b1, 8'h00, 8'd11},  // R11
    '{1'b0, 2'd0, 8'h00, 1'b1, 8'h02, 8'd11},  // R11 ptr untouched
    '{1'b0, 2'd2, 8'h00, 1'b1, 8'h55, 8'd11}   // R11 data untouched
  };

  task automatic check(input string tag, input logic [7:0] got, input logic [7:0] exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s: got %02h expected %02h", tag, got, exp);
    end
  endtask

  // One access cycle, then two idle cycles for the internal RAM operation.
  task automatic access(input logic wr, input logic [1:0] a, input logic [7:0] d,
                        output logic [7:0] q);
    @(negedge clk);
    host_sel = 1'b1; host_wr = wr; host_addr = a; host_wdata = d;
    #1;
    q = host_rdata;  // R10: same-cycle read data
    @(negedge clk);
    host_sel = 1'b0; host_wr = 1'b0; host_wdata = 8'h00;
    @(negedge clk);
  endtask

  task automatic do_reset();
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
  endtask

  initial begin
    logic [7:0] q;
    host_sel = 1'b0; host_wr = 1'b0; host_addr = 2'd0; host_wdata = 8'h00;
    do_reset();

    // R1 reset values
    access(1'b0, 2'd0, 8'h00, q); check("R1 ptr low", q, 8'h00);
    access(1'b0, 2'd1, 8'h00, q); check("R1 ptr high", q, 8'h00);
    access(1'b0, 2'd2, 8'h00, q); check("R1 data", q, 8'h00);

    for (int i = 0; i < NV; i++) begin
      access(VEC[i].wr, VEC[i].sel, VEC[i].wd, q);
      if (VEC[i].chk) check($sformatf("R%0d vec %0d", VEC[i].req, i), q, VEC[i].exp);
    end

    // R1 reset in mid-run clears pointer, mode and data
    do_reset();
    access(1'b0, 2'd0, 8'h00, q); check("R1 ptr low after reset", q, 8'h00);
    access(1'b0, 2'd1, 8'h00, q); check("R1 mode after reset", q, 8'h00);
    access(1'b0, 2'd2, 8'h00, q); check("R1 data after reset", q, 8'h00);

    // R4 prefetch after reset still reaches stored contents (RAM not cleared)
    access(1'b1, 2'd1, 8'h40, q);
    access(1'b1, 2'd0, 8'h01, q);
    access(1'b0, 2'd2, 8'h00, q); check("R4 prefetch @001", q, 8'h44);

    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    #400000;
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule